// File: doc/BRIEF.md
# Instruction-Driven Register-ALU Datapath

This block is the execute core of a very small processor. It takes one 32-bit instruction word per clock on a valid/ready input stream. It splits the word into an operation code, two source register indices and a destination register index. It reads both sources from a clocked 32-entry register file and combines them in an arithmetic/logic unit. One clock later it writes the result into the destination register.

The register file is enabled only when the operation code is one of the five defined codes. Any other word leaves every register and every output untouched. Each write-back is also announced on a small result stream (strobe, destination index, data), so that surrounding logic or a test environment can follow every update.

The register file loads a known seed when reset, so results can be predicted from the first instruction on. The core never applies back-pressure once it is out of reset. The result stream has no ready signal: a consumer must take each result in the cycle it is shown.

Top module: `regalu_core`

## Requirements
- R1: An instruction word is laid out, most significant bit first, as op code [31:26], first source index [25:21], second source index [20:16], destination index [15:11] and spare bits [10:0]. The op codes are 0x01 add, 0x02 subtract, 0x03 bitwise AND, 0x04 bitwise OR and 0x05 bitwise XOR.
- R2: For op code 0x01 the destination receives first source plus second source, modulo 2^DATA_W. For example, sources 1 and 2 with destination 3 leave register 3 holding the sum of registers 1 and 2.
- R3: Op code 0x02 stores first source minus second source, modulo 2^DATA_W. Op codes 0x03, 0x04 and 0x05 store the bitwise AND, OR and XOR of the two sources.
- R4: A word whose op code is 0x00 or 0x06 to 0x3F is dropped. No register changes and no result is announced.
- R5: A word accepted at clock edge N has its result written at edge N+1. From edge N+1 until the next edge, `wb_valid` is 1 and `wb_dest`/`wb_data` show that destination and value. In every other cycle `wb_valid` is 0.
- R6: Source reads happen at the acceptance edge and see the register contents from before any write at that same edge. A word that depends on the previous word's destination therefore reads the old value when issued on the very next cycle, and the new value when one idle cycle separates them.
- R7: While `rst_n` is low, register i holds the value i, `in_ready` is 0 and `wb_valid` is 0. From the first edge after reset is released, `in_ready` is 1 and stays 1.
- R8: The spare bits [10:0] have no effect on the result or the destination.
- R9: A word presented with `in_valid` low is ignored, whatever its op code.
- R10: The same register may be named as both sources and the destination. The result is computed from its value before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word on `in_instr` is offered |
| in_ready | output | 1 | Core accepts a word this cycle (constant 1 after reset) |
| in_instr | input | 32 | Instruction word |
| wb_valid | output | 1 | A result was written at the last edge |
| wb_dest | output | 5 | Destination register of that result |
| wb_data | output | DATA_W | Value written |

## Verification
The hardest case to reach from the ports is a write and a read of the same register at the same edge: the result of one word must land while the next word reads that register. The bench reaches it by issuing a dependent word on the cycle right after its producer. It then repeats the pair with one idle cycle between them and checks that the newer value appears. Register contents are otherwise hidden, so after every dropped word the bench reads the affected register back through an OR of that register with itself. This confirms that no state changed.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int IDX_W   = 5;
  localparam int SPARE_W = INSTR_W - OPC_W - 3 * IDX_W;
  localparam int NREGS   = 1 << IDX_W;

  // Field order from the top bit down: code, src a, src b, dest, spare.
  typedef struct packed {
    logic [OPC_W-1:0]   opc;
    logic [IDX_W-1:0]   src_a;
    logic [IDX_W-1:0]   src_b;
    logic [IDX_W-1:0]   dest;
    logic [SPARE_W-1:0] spare;
  } instr_t;

  localparam logic [OPC_W-1:0] OPC_ADD = 6'h01;
  localparam logic [OPC_W-1:0] OPC_SUB = 6'h02;
  localparam logic [OPC_W-1:0] OPC_AND = 6'h03;
  localparam logic [OPC_W-1:0] OPC_OR  = 6'h04;
  localparam logic [OPC_W-1:0] OPC_XOR = 6'h05;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR
  } alu_op_e;

endpackage

// File: rtl/regalu_decode.sv
module regalu_decode
  import regalu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output logic               op_ok,
  output alu_op_e            alu_op,
  output logic [IDX_W-1:0]   src_a,
  output logic [IDX_W-1:0]   src_b,
  output logic [IDX_W-1:0]   dest
);

  instr_t fields;

  assign fields = instr_t'(instr);
  assign src_a  = fields.src_a;
  assign src_b  = fields.src_b;
  assign dest   = fields.dest;

  always_comb begin
    op_ok  = 1'b1;
    alu_op = ALU_ADD;
    unique case (fields.opc)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_SUB: alu_op = ALU_SUB;
      OPC_AND: alu_op = ALU_AND;
      OPC_OR:  alu_op = ALU_OR;
      OPC_XOR: alu_op = ALU_XOR;
      default: op_ok  = 1'b0;
    endcase
  end

endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/regalu_regfile.sv
module regalu_regfile #(
  parameter int DATA_W = 32,
  parameter int NREGS  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [$clog2(NREGS)-1:0] ra_a,
  input  logic [$clog2(NREGS)-1:0] ra_b,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] wa,
  input  logic [DATA_W-1:0]        wd,
  output logic [DATA_W-1:0]        rdata_a,
  output logic [DATA_W-1:0]        rdata_b
);

  localparam int AW = $clog2(NREGS);

  logic [DATA_W-1:0] cells [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cell_q <= DATA_W'(g);
      else if (we && wa == AW'(g))
        cell_q <= wd;
    end
    assign cells[g] = cell_q;
  end

  // Reads sample the array before any same-edge write lands.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_a <= '0;
      rdata_b <= '0;
    end else if (rd_en) begin
      rdata_a <= cells[ra_a];
      rdata_b <= cells[ra_b];
    end
  end

endmodule

// File: rtl/regalu_core.sv
module regalu_core
  import regalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_instr,
  output logic              wb_valid,
  output logic [4:0]        wb_dest,
  output logic [DATA_W-1:0] wb_data
);

  logic             ready_q;
  logic             dec_ok;
  alu_op_e          dec_op;
  logic [IDX_W-1:0] dec_a, dec_b, dec_d;
  logic             rf_en;

  logic             ex_valid_q;
  alu_op_e          ex_op_q;
  logic [IDX_W-1:0] ex_dest_q;
  logic [DATA_W-1:0] opnd_a, opnd_b, alu_y;

  logic              wb_valid_q;
  logic [IDX_W-1:0]  wb_dest_q;
  logic [DATA_W-1:0] wb_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  regalu_decode u_dec (
    .instr  (in_instr),
    .op_ok  (dec_ok),
    .alu_op (dec_op),
    .src_a  (dec_a),
    .src_b  (dec_b),
    .dest   (dec_d)
  );

  assign rf_en = in_valid && ready_q && dec_ok;

  regalu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rf_en),
    .ra_a    (dec_a),
    .ra_b    (dec_b),
    .we      (ex_valid_q),
    .wa      (ex_dest_q),
    .wd      (alu_y),
    .rdata_a (opnd_a),
    .rdata_b (opnd_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_valid_q <= 1'b0;
      ex_op_q    <= ALU_ADD;
      ex_dest_q  <= '0;
    end else begin
      ex_valid_q <= rf_en;
      if (rf_en) begin
        ex_op_q   <= dec_op;
        ex_dest_q <= dec_d;
      end
    end
  end

  regalu_alu #(.DATA_W(DATA_W)) u_alu (
    .op (ex_op_q),
    .a  (opnd_a),
    .b  (opnd_b),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid_q <= 1'b0;
      wb_dest_q  <= '0;
      wb_data_q  <= '0;
    end else begin
      wb_valid_q <= ex_valid_q;
      if (ex_valid_q) begin
        wb_dest_q <= ex_dest_q;
        wb_data_q <= alu_y;
      end
    end
  end

  assign in_ready = ready_q;
  assign wb_valid = wb_valid_q;
  assign wb_dest  = wb_dest_q;
  assign wb_data  = wb_data_q;

endmodule

// File: rtl/regalu_core_chk.sv
module regalu_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [31:0]       in_instr,
  input logic              wb_valid,
  input logic [4:0]        wb_dest,
  input logic [DATA_W-1:0] wb_data
);

  logic code_ok;
  logic take_ok;
  logic take_bad;

  assign code_ok  = in_instr[31:26] >= 6'h01 && in_instr[31:26] <= 6'h05;
  assign take_ok  = in_valid && in_ready && code_ok;
  assign take_bad = in_valid && in_ready && !code_ok;

  assert_result_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok |-> ##2 wb_valid);

  assert_result_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(take_ok, 2));

  assert_bad_code_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_bad |-> ##2 !wb_valid);

  assert_dest_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_dest == $past(in_instr[15:11], 2));

  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(in_ready));

  assert_data_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !$isunknown(wb_data));

endmodule

bind regalu_core regalu_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_instr (in_instr),
  .wb_valid (wb_valid),
  .wb_dest  (wb_dest),
  .wb_data  (wb_data)
);

// File: tb/regalu_core_bench.sv
module regalu_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_instr;
  logic        wb_valid;
  logic [4:0]  wb_dest;
  logic [31:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] model [32];

  always #2 clk = ~clk;

  regalu_core #(.DATA_W(32)) u_regalu_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_instr (in_instr),
    .wb_valid (wb_valid),
    .wb_dest  (wb_dest),
    .wb_data  (wb_data)
  );

  function automatic logic [31:0] word(input logic [5:0] opc, input int a, input int b,
                                       input int d, input logic [10:0] spare);
    return {opc, 5'(a), 5'(b), 5'(d), spare};
  endfunction

  function automatic logic [31:0] expect_val(input logic [5:0] opc, input logic [31:0] a,
                                             input logic [31:0] b);
    case (opc)
      6'h01:   return a + b;
      6'h02:   return a - b;
      6'h03:   return a & b;
      6'h04:   return a | b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Issue one word, then idle, and check the result stream.
  task automatic run_one(input logic [5:0] opc, input int a, input int b, input int d,
                         input logic [10:0] spare, input string req);
    logic [31:0] exp;
    bit good;
    good = (opc >= 6'h01 && opc <= 6'h05);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = word(opc, a, b, d, spare);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(wb_valid == 1'b0, req, "strobe one cycle early", 32'(wb_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    if (good) begin
      exp = expect_val(opc, model[a], model[b]);
      chk(wb_valid == 1'b1, req, "strobe", 32'(wb_valid), 32'd1);
      chk(wb_dest == 5'(d), req, "dest", 32'(wb_dest), 32'(d));
      chk(wb_data == exp, req, "data", wb_data, exp);
      model[d] = exp;
    end else begin
      chk(wb_valid == 1'b0, req, "dropped word strobe", 32'(wb_valid), 32'd0);
    end
  endtask

  task automatic peek(input int r, input string req);
    run_one(6'h04, r, r, r, 11'h0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] old5, exp_a, exp_b;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_instr = '0;
    for (int i = 0; i < 32; i++) model[i] = 32'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b0, "R7", "ready in reset", 32'(in_ready), 32'd0);
    chk(wb_valid == 1'b0, "R7", "strobe in reset", 32'(wb_valid), 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7", "ready after reset", 32'(in_ready), 32'd1);

    // R7: seed value i in register i
    for (int r = 0; r < 32; r++) peek(r, "R7");

    // R2: worked example, sources 1 and 2 into 3
    run_one(6'h01, 1, 2, 3, 11'h0, "R2");

    // R2 / R3 / R1: sweep every code over every first-source index
    for (int op = 1; op <= 5; op++) begin
      for (int i = 0; i < 32; i++) begin
        run_one(6'(op), i, (i * 7 + 3) % 32, (i + 11) % 32, 11'h0,
                (op == 1) ? "R2" : "R3");
      end
    end

    // R10: one register as both sources and destination
    run_one(6'h01, 9, 9, 9, 11'h0, "R10");
    run_one(6'h05, 9, 9, 9, 11'h0, "R10");
    run_one(6'h02, 4, 4, 4, 11'h0, "R10");

    // R4: every undefined code is dropped; the destination is then read back
    for (int op = 0; op < 64; op++) begin
      if (op == 0 || op > 5) begin
        run_one(6'(op), op % 32, (op + 1) % 32, (op + 5) % 32, 11'h0, "R4");
        peek((op + 5) % 32, "R4");
      end
    end

    // R8: spare bits set
    run_one(6'h01, 6, 7, 8, 11'h7FF, "R8");
    run_one(6'h05, 10, 12, 14, 11'h555, "R8");

    // R9: a good word with in_valid low does nothing
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = word(6'h01, 1, 2, 7, 11'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wb_valid == 1'b0, "R9", "strobe with valid low", 32'(wb_valid), 32'd0);
    peek(7, "R9");

    // R6: dependent word on the very next cycle reads the old value
    old5  = model[5];
    exp_a = model[1] + model[2];
    exp_b = old5 ^ model[6];
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = word(6'h01, 1, 2, 5, 11'h0);
    @(posedge clk);
    @(negedge clk);
    in_instr = word(6'h05, 5, 6, 20, 11'h0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(wb_valid && wb_dest == 5'd5, "R6", "producer strobe/dest", 32'(wb_dest), 32'd5);
    chk(wb_data == exp_a, "R6", "producer data", wb_data, exp_a);
    @(posedge clk);
    @(negedge clk);
    chk(wb_valid && wb_dest == 5'd20, "R6", "consumer strobe/dest", 32'(wb_dest), 32'd20);
    chk(wb_data == exp_b, "R6", "consumer saw old value", wb_data, exp_b);
    model[5]  = exp_a;
    model[20] = exp_b;
    @(posedge clk);
    @(negedge clk);
    chk(wb_valid == 1'b0, "R5", "strobe drops after one cycle", 32'(wb_valid), 32'd0);

    // R6: with one idle cycle the new value is seen
    run_one(6'h01, 1, 2, 5, 11'h0, "R6");
    run_one(6'h05, 5, 6, 21, 11'h0, "R6");

    for (int r = 0; r < 32; r++) peek(r, "R5");

    finish_run();
  end

endmodule